// File: doc/BRIEF.md
# Switching Clock Source Selector

This block decides what paces a buck converter's switching cycles. A three-level strap picks one of three modes. In the first mode the block runs its own oscillator and drives that clock out so that neighbouring converters can follow it. In the second mode it follows a sync clock supplied from outside. In the third mode it follows an outside clock if a usable one is present, and otherwise runs at a frequency chosen by a second strap. The output is a one-cycle switching tick in the system clock domain, together with a status code that reports which source is pacing that tick.

All timing is counted in system clock cycles. The interval between two rising edges of the sync input is measured as a cycle count. The outside clock is accepted only after a run of consistent, in-range intervals. Once accepted, every tick is placed at a fixed delay after a sync rising edge. If the sync edges stop, the block does not stall. It keeps ticking from its own counter at the last accepted interval. Detection runs again each time enable rises.

Top module: `swclk_src_sel`

## Requirements
- R1: The mode strap `cfg_mode` is coded as follows: 2'b10 or 2'b11 means high (internal, drive out), 2'b00 means low (external), and 2'b01 means floating (auto-detect). When enable rises with the strap high, `tick` pulses every INT_PERIOD cycles and `src_status` reads 1 (internal). `sync_oe` is 1, and `sync_out` is high for the first INT_PERIOD/2 cycles of each period. Activity on `sync_in` has no effect in this mode.
- R2: With the strap low, each rise of `en` starts a new acquisition. After lock, `src_status` reads 2 (external). `tick` is high in the cycle that follows the third rising `clk` edge after `sync_in` goes high: two synchronizer stages plus one output register.
- R3: Lock requires three consecutive sync intervals. Each interval must lie in [MIN_PERIOD, MAX_PERIOD], and each must differ from the one before it by no more than that earlier interval shifted right by TOL_SHIFT (5, about 3%). Until lock in external mode, `src_status` reads 0 and no tick is produced.
- R4: While locked, if no sync rising edge arrives within twice the locked interval, `src_status` reads 3 (holdover). Ticks then repeat at the last in-range interval measured.
- R5: In auto-detect mode a lock gives external operation, as in R2. If there is no lock within ACQ_WIN cycles, ticks repeat every INT_PERIOD + code×(INT_PERIOD/2) cycles, where code is the 2-bit `strap_sel`, and `src_status` reads 1.
- R6: `strap_sel` is captured in the first cycle after reset release. Later changes to it have no effect until the next reset.
- R7: While `en` is low, `src_status` reads 0, no tick is produced and `sync_oe` is 0. Raising `en` again repeats detection.
- R8: During reset `tick`, `src_status` and `sync_oe` are 0. `tick` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Converter enable; a rise starts detection |
| cfg_mode | input | 2 | Three-level mode strap, coded as in R1 |
| strap_sel | input | 2 | Fallback frequency code for auto-detect mode |
| sync_in | input | 1 | Sync clock from outside |
| tick | output | 1 | One-cycle switching tick |
| src_status | output | 2 | 0 none, 1 internal, 2 external, 3 holdover |
| sync_out | output | 1 | Internal clock driven out in internal mode |
| sync_oe | output | 1 | Output enable for `sync_out` |

## Verification
The bench builds the block with INT_PERIOD 24, MIN_PERIOD 16 and MAX_PERIOD 64, which makes ACQ_WIN 384 cycles. With these values, the range edges, the auto-detect timeout and the loss timeout all arrive within a few hundred cycles. Intervals in the 32 to 63 range allow exactly one count of disagreement, so a 40/41 alternation locks and a 40/44 alternation does not. The four fallback straps give distinct periods (24, 36, 48, 60) that can be told apart.

// File: rtl/swclk_pkg.sv
package swclk_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_INT  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_HOLD = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INTOUT = 3'd1,
    ST_ACQ    = 3'd2,
    ST_EXT    = 3'd3,
    ST_HOLD   = 3'd4,
    ST_STRAP  = 3'd5
  } st_e;
endpackage

// File: rtl/swclk_meter.sv
// Synchronizes the sync input, finds rising edges and counts the cycles since the last one.
module swclk_meter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sync_in,
  output logic         rise,
  output logic         meas_vld,
  output logic [W-1:0] since
);
  logic s1_q, s2_q, s3_q;
  logic have_q, have_n;
  logic [W-1:0] cnt_q, cnt_n;

  assign rise     = s2_q & ~s3_q;
  assign meas_vld = rise & have_q & ~clear;
  assign since    = cnt_q;

  always_comb begin
    cnt_n  = cnt_q;
    have_n = have_q;
    if (clear) begin
      cnt_n  = '0;
      have_n = 1'b0;
    end else if (rise) begin
      cnt_n  = W'(1);
      have_n = 1'b1;
    end else if (cnt_q != '1) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= sync_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      have_q <= have_n;
      cnt_q  <= cnt_n;
    end
  end

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/swclk_qual.sv
// Tracks a run of consistent in-range intervals and flags lock on the last one of the run.
module swclk_qual #(
  parameter int W          = 10,
  parameter int MIN_PERIOD = 100,
  parameter int MAX_PERIOD = 500,
  parameter int AGREE_CNT  = 3,
  parameter int TOL_SHIFT  = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         meas_vld,
  input  logic [W-1:0] meas,
  output logic         in_rng,
  output logic         lock
);
  localparam int N_W = $clog2(AGREE_CNT + 1);

  logic [W-1:0]   last_q, last_n, diff;
  logic [N_W-1:0] run_q, run_n;
  logic           close;

  always_comb begin
    diff   = (meas > last_q) ? (meas - last_q) : (last_q - meas);
    close  = (run_q != '0) && (diff <= (last_q >> TOL_SHIFT));
    in_rng = (meas >= W'(MIN_PERIOD)) && (meas <= W'(MAX_PERIOD));
    lock   = meas_vld && in_rng && close && (run_q == N_W'(AGREE_CNT - 1));
    run_n  = run_q;
    last_n = last_q;
    if (clear) begin
      run_n = '0;
    end else if (meas_vld) begin
      last_n = meas;
      if (!in_rng)                                      run_n = '0;
      else if (!close)                                  run_n = N_W'(1);
      else if (run_q != N_W'(AGREE_CNT))                run_n = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= '0;
    end else begin
      run_q  <= run_n;
      last_q <= last_n;
    end
  end

  AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> $past(meas_vld) || $past(run_q) != '0); // R3
endmodule

// File: rtl/swclk_ticker.sv
// Free-running phase counter; fires once per period while running.
module swclk_ticker #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic         fire,
  output logic [W-1:0] phase
);
  logic [W-1:0] ph_q, ph_n;

  assign phase = ph_q;
  assign fire  = run && !restart && (ph_q >= period);

  always_comb begin
    if (!run || restart || (ph_q >= period)) ph_n = W'(1);
    else                                     ph_n = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= W'(1);
    else        ph_q <= ph_n;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_q <= period)); // R1
endmodule

// File: rtl/swclk_src_sel.sv
module swclk_src_sel
  import swclk_pkg::*;
#(
  parameter int INT_PERIOD = 250,
  parameter int MIN_PERIOD = 100,
  parameter int MAX_PERIOD = 500,
  parameter int AGREE_CNT  = 3,
  parameter int TOL_SHIFT  = 5,
  parameter int ACQ_WIN    = 6 * MAX_PERIOD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] strap_sel,
  input  logic       sync_in,
  output logic       tick,
  output logic [1:0] src_status,
  output logic       sync_out,
  output logic       sync_oe
);
  localparam int SPAN     = (2 * MAX_PERIOD > 3 * INT_PERIOD) ? 2 * MAX_PERIOD : 3 * INT_PERIOD;
  localparam int CNT_W    = $clog2(SPAN + 2);
  localparam int WIN_W    = $clog2(ACQ_WIN + 1);
  localparam int N_STRAP  = 4;

  // reset: asserted at once, released through two flops
  logic rs1_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  st_e              state_q, state_n;
  logic             auto_q, auto_n;
  logic [WIN_W-1:0] win_q, win_n;
  logic [CNT_W-1:0] plock_q, plock_n;
  logic             start_q;
  logic [1:0]       strap_q;
  logic             tick_q, tick_n;
  logic             meas_clr, rise, meas_vld, in_rng, lock, loss;
  logic [CNT_W-1:0] since, cur_per, phase;
  logic             run, restart, fire;
  logic [CNT_W-1:0] strap_tab [N_STRAP];

  for (genvar g = 0; g < N_STRAP; g++) begin : g_strap
    assign strap_tab[g] = CNT_W'(INT_PERIOD + g * (INT_PERIOD / 2));
  end

  assign meas_clr = !(state_q == ST_ACQ || state_q == ST_EXT);

  swclk_meter #(.W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_i), .clear(meas_clr), .sync_in(sync_in),
    .rise(rise), .meas_vld(meas_vld), .since(since)
  );

  swclk_qual #(
    .W(CNT_W), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
    .AGREE_CNT(AGREE_CNT), .TOL_SHIFT(TOL_SHIFT)
  ) u_qual (
    .clk(clk), .rst_n(rst_i), .clear(meas_clr), .meas_vld(meas_vld),
    .meas(since), .in_rng(in_rng), .lock(lock)
  );

  assign loss = !rise && ({1'b0, since} >= {plock_q, 1'b0});

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_OFF:   if (en) state_n = cfg_mode[1] ? ST_INTOUT : ST_ACQ;
      ST_ACQ:   if (lock) state_n = ST_EXT;
                else if (auto_q && win_q == WIN_W'(ACQ_WIN - 1)) state_n = ST_STRAP;
      ST_EXT:   if (loss) state_n = ST_HOLD;
      default:  state_n = state_q;
    endcase
    if (!en) state_n = ST_OFF;
  end

  always_comb begin
    auto_n  = (state_q == ST_OFF) ? (cfg_mode == 2'b01) : auto_q;
    win_n   = '0;
    if (state_q == ST_ACQ && win_q != WIN_W'(ACQ_WIN - 1)) win_n = win_q + 1'b1;
    plock_n = plock_q;
    if ((state_q == ST_ACQ && lock) || (state_q == ST_EXT && meas_vld && in_rng))
      plock_n = since;
  end

  always_comb begin
    unique case (state_q)
      ST_STRAP: cur_per = strap_tab[strap_q];
      ST_HOLD:  cur_per = plock_q;
      default:  cur_per = CNT_W'(INT_PERIOD);
    endcase
    run     = (state_q == ST_INTOUT) || (state_q == ST_STRAP) || (state_q == ST_HOLD);
    restart = (state_n != state_q);
    tick_n  = fire || (state_q == ST_EXT && rise);
  end

  swclk_ticker #(.W(CNT_W)) u_ticker (
    .clk(clk), .rst_n(rst_i), .run(run), .restart(restart),
    .period(cur_per), .fire(fire), .phase(phase)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_OFF;
      auto_q  <= 1'b0;
      win_q   <= '0;
      plock_q <= CNT_W'(MAX_PERIOD);
      start_q <= 1'b0;
      strap_q <= 2'b00;
      tick_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      auto_q  <= auto_n;
      win_q   <= win_n;
      plock_q <= plock_n;
      tick_q  <= tick_n;
      if (!start_q) begin
        start_q <= 1'b1;
        strap_q <= strap_sel;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_INTOUT, ST_STRAP: src_status = SRC_INT;
      ST_EXT:              src_status = SRC_EXT;
      ST_HOLD:             src_status = SRC_HOLD;
      default:             src_status = SRC_NONE;
    endcase
  end

  assign tick     = tick_q;
  assign sync_oe  = (state_q == ST_INTOUT);
  assign sync_out = sync_oe && (phase <= CNT_W'(INT_PERIOD / 2));

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    tick_q |=> !tick_q); // R8
  AST_INT_STAYS: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_INTOUT) |=> (state_q == ST_INTOUT || state_q == ST_OFF)); // R1
  AST_EXT_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(state_q == ST_EXT) |-> $past(lock)); // R3
  AST_LOSS_WINDOW: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_EXT) |-> ({1'b0, since} <= {plock_q, 1'b0})); // R4
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_i)
    start_q |=> $stable(strap_q)); // R6
  AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_i)
    !en |=> (state_q == ST_OFF)); // R7
endmodule

// File: tb/swclk_src_sel_bench.sv
module swclk_src_sel_bench;
  localparam int INT_P = 24;
  localparam int MIN_P = 16;
  localparam int MAX_P = 64;

  logic       clk = 1'b0;
  logic       rst_n, en, sync_in;
  logic [1:0] cfg_mode, strap_sel;
  logic       tick, sync_out, sync_oe;
  logic [1:0] src_status;

  int  gen_pa = 0, gen_pb = 0;
  int  n_chk = 0, n_bad = 0, dbl = 0;
  bit  prev_tick = 1'b0;
  int  ga, gb;

  always #4 clk = ~clk;

  swclk_src_sel #(.INT_PERIOD(INT_P), .MIN_PERIOD(MIN_P), .MAX_PERIOD(MAX_P)) u_swclk_src_sel (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode), .strap_sel(strap_sel),
    .sync_in(sync_in), .tick(tick), .src_status(src_status),
    .sync_out(sync_out), .sync_oe(sync_oe)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] strap;
    logic [7:0] pa;
    logic [7:0] pb;
    logic [1:0] st;
    logic [7:0] iv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd0, 8'd0,  8'd0,  2'd1, 8'd24},
    '{2'd2, 2'd0, 8'd40, 8'd40, 2'd1, 8'd24},
    '{2'd0, 2'd0, 8'd40, 8'd40, 2'd2, 8'd40},
    '{2'd0, 2'd0, 8'd16, 8'd16, 2'd2, 8'd16},
    '{2'd0, 2'd0, 8'd64, 8'd64, 2'd2, 8'd64},
    '{2'd0, 2'd0, 8'd12, 8'd12, 2'd0, 8'd0},
    '{2'd0, 2'd0, 8'd70, 8'd70, 2'd0, 8'd0},
    '{2'd0, 2'd0, 8'd40, 8'd41, 2'd2, 8'd40},
    '{2'd0, 2'd0, 8'd40, 8'd44, 2'd0, 8'd0},
    '{2'd1, 2'd0, 8'd40, 8'd40, 2'd2, 8'd40},
    '{2'd1, 2'd0, 8'd0,  8'd0,  2'd1, 8'd24},
    '{2'd1, 2'd2, 8'd0,  8'd0,  2'd1, 8'd48},
    '{2'd1, 2'd1, 8'd70, 8'd70, 2'd1, 8'd36},
    '{2'd3, 2'd3, 8'd0,  8'd0,  2'd1, 8'd24}
  };

  task automatic one_period(int p);
    sync_in = 1'b1;
    repeat (p / 2) @(negedge clk);
    sync_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  initial begin
    sync_in = 1'b0;
    @(negedge clk);
    forever begin
      ga = gen_pa;
      if (ga == 0) begin
        sync_in = 1'b0;
        @(negedge clk);
      end else begin
        one_period(ga);
        gb = (gen_pb == 0) ? gen_pa : gen_pb;
        if (gb != 0) one_period(gb);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
    if (tick && prev_tick) dbl++;
    prev_tick = tick;
  endtask

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic measure(output int iv);
    int n;
    iv = 0;
    n = 0;
    while (!tick && n < 300) begin step(); n++; end
    if (!tick) return;
    n = 0;
    do begin step(); n++; end while (!tick && n < 300);
    if (tick) iv = n;
  endtask

  task automatic do_reset(logic [1:0] strap);
    en = 1'b0;
    rst_n = 1'b0;
    strap_sel = strap;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int iv, n, cnt;
    bit ps, t1, t2, t3;
    string tg;
    rst_n = 1'b0; en = 1'b0; cfg_mode = 2'd0; strap_sel = 2'd0;
    repeat (3) step();
    chk(tick == 1'b0, "R8 reset tick", int'(tick), 0);
    chk(src_status == 2'd0, "R8 reset status", int'(src_status), 0);
    chk(sync_oe == 1'b0, "R8 reset sync_oe", int'(sync_oe), 0);
    rst_n = 1'b1;
    repeat (4) step();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      gen_pa = int'(v.pa);
      gen_pb = int'(v.pb);
      cfg_mode = v.mode;
      do_reset(v.strap);
      en = 1'b1;
      repeat (512) step();
      tg = v.mode[1] ? "R1" : ((v.mode == 2'd1) ? "R5" : ((v.st == 2'd2) ? "R2" : "R3"));
      chk(src_status == v.st, $sformatf("%s vec%0d status", tg, i), int'(src_status), int'(v.st));
      measure(iv);
      chk(iv == int'(v.iv) || (v.pa != v.pb && v.st == 2'd2 && iv == int'(v.pb)),
          $sformatf("%s vec%0d tick interval", tg, i), iv, int'(v.iv));
      chk(sync_oe == v.mode[1], $sformatf("R1 vec%0d sync_oe", i), int'(sync_oe), int'(v.mode[1]));
    end

    // R2 alignment of tick to sync rising edge
    gen_pa = 41; gen_pb = 0; cfg_mode = 2'd0;
    do_reset(2'd0);
    en = 1'b1;
    repeat (512) step();
    chk(src_status == 2'd2, "R2 locked at 41", int'(src_status), 2);
    n = 0;
    do begin ps = sync_in; step(); n++; end while (!(sync_in && !ps) && n < 200);
    step(); t1 = tick;
    step(); t2 = tick;
    step(); t3 = tick;
    chk(!t1 && !t2, "R2 no early tick", int'(t1) + int'(t2), 0);
    chk(t3, "R2 tick three edges after sync rise", int'(t3), 1);

    // R4 loss of sync -> holdover at last interval
    gen_pa = 0;
    repeat (300) step();
    chk(src_status == 2'd3, "R4 holdover status", int'(src_status), 3);
    measure(iv);
    chk(iv == 41, "R4 holdover interval", iv, 41);

    // R7 enable low silences, re-enable re-detects
    gen_pa = 40;
    en = 1'b0;
    step(); step();
    chk(src_status == 2'd0, "R7 status with en low", int'(src_status), 0);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin step(); if (tick) cnt++; end
    chk(cnt == 0, "R7 ticks with en low", cnt, 0);
    chk(sync_oe == 1'b0, "R7 sync_oe with en low", int'(sync_oe), 0);
    en = 1'b1;
    repeat (512) step();
    chk(src_status == 2'd2, "R7 re-detect status", int'(src_status), 2);
    measure(iv);
    chk(iv == 40, "R7 re-detect interval", iv, 40);

    // R6 strap change after startup ignored
    gen_pa = 0; cfg_mode = 2'd1;
    do_reset(2'd0);
    strap_sel = 2'd3;
    en = 1'b1;
    repeat (512) step();
    chk(src_status == 2'd1, "R6 fallback status", int'(src_status), 1);
    measure(iv);
    chk(iv == INT_P, "R6 late strap ignored", iv, INT_P);

    // R1 driven clock shape
    cfg_mode = 2'd2;
    do_reset(2'd0);
    en = 1'b1;
    repeat (10) step();
    cnt = 0;
    for (int k = 0; k < 2 * INT_P; k++) begin step(); if (sync_out) cnt++; end
    chk(cnt == INT_P, "R1 sync_out high count", cnt, INT_P);

    chk(dbl == 0, "R8 double-width ticks", dbl, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule